// File: doc/BRIEF.md
# SD Host Interrupt Status Register

This block holds the 32-bit interrupt status word of an SD/SDIO host controller. The upper half collects error conditions and the lower half collects normal completion and buffer events. Engines elsewhere in the controller raise single-cycle event pulses, and each pulse sets its status bit. Software reads the word through a small register port and clears bits by writing ones to them.

Some bits follow their own rules. A read-only summary bit reports whether any error is pending, and it drops by itself when the last error is cleared. The card-interrupt bit follows the card's interrupt line and its enable bit. The write-one-to-clear path cannot clear it. Two error bits are detected inside the block. The first flags an access to the data-port register while the buffer does not allow that direction. The second flags error bits in a card-status response, after filtering by a software error-enable mask.

The register port carries the status word, a one-bit card-interrupt enable, the 32-bit card-status error-enable mask and the data-port address. Read data is registered and appears one cycle after the request.

Top module: `sd_irq_status`

## Requirements
- R1: After reset every status bit, the card-interrupt enable and the error-enable mask read as 0, and `reg_rdata` is 0.
- R2: A one-cycle pulse on `norm_evt[i]` for i in {0..7, 9, 10} sets status bit i. A pulse on `err_evt[j]` for j in {0..6, 8, 9} sets status bit 16+j. Pulses at any other position of either vector have no effect.
- R3: Writing address 0 clears each writable status bit (bits 0..7, 9, 10, 16..22, 24, 25, 28, 29) whose data bit is 1. Bits written with 0 keep their value.
- R4: When a set event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R5: Bit 15 reads 1 exactly when any bit of 31:16 is 1. Writing 1 to bit 15 does nothing, and bit 15 returns to 0 in the same cycle the last error bit is cleared.
- R6: Bit 8 sets while `card_irq` is 1 and the enable (address 1, data bit 8) is 1. Writing 1 to status bit 8 does not clear it. It clears only when the enable is 0 and `card_irq` is 0. While the enable is 0, `card_irq` does not set it.
- R7: Bit 29 sets on a read of address 3 while `buf_rd_ok` is 0, or on a write of address 3 while `buf_wr_ok` is 0. Accesses allowed by these inputs leave it unchanged.
- R8: Bit 28 sets on `rsp_valid` when four things hold. The response kind (`rsp_kind`: 0 none, 1 R1, 2 R1b, 3 R2, 4 R3, 5 R5, 6 R5b, 7 R6) is 1, 2, 5, 6 or 7. The response status has a 1 at an error-class position (mask `0xFDF98008`). The error-enable mask (address 2) has a 1 at the same position. `rsp_auto12` is 0.
- R9: A response with `rsp_auto12` = 1 never sets bit 28.
- R10: Status bits 31:30, 27:26, 23 and 14:11 always read 0, and writes do not change them. The enable register reads 0 outside bit 8.
- R11: A read of address 0, 1, 2 or 3 returns, one cycle later, the status word, the enable, the error-enable mask, or 0 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| norm_evt | input | 16 | Normal event pulses (lower half) |
| err_evt | input | 16 | Error event pulses (upper half) |
| card_irq | input | 1 | Card interrupt level |
| buf_rd_ok | input | 1 | Buffer currently allows data-port reads |
| buf_wr_ok | input | 1 | Buffer currently allows data-port writes |
| rsp_valid | input | 1 | A command response has been received |
| rsp_kind | input | 3 | Response kind code |
| rsp_auto12 | input | 1 | Response belongs to the automatic stop command |
| rsp_status | input | 32 | Card status field of the response |

## Verification
An event pulse, a write-one clear, a data-port access or a response updates the status word at the clock edge that samples it. A read request returns the word as it stood before that same edge, so any change shows up only in a read issued one cycle or more after the stimulus. The card-interrupt bit goes through one register stage after `card_irq` or the enable changes. The bench drives every stimulus on a falling edge, finishes it before it starts a read, and samples `reg_rdata` on the falling edge one cycle after the read request. The same-cycle set and clear case is driven in a single cycle.

// File: rtl/sdis_pkg.sv
// Shared constants and codes for the SD interrupt status block.
// Assumes a 32-bit status word with errors in the upper half.
package sdis_pkg;
    localparam int STAT_W = 32;
    localparam int HALF_W = STAT_W / 2;
    localparam int ADDR_W = 2;

    localparam int BIT_CIRQ   = 8;
    localparam int BIT_ERRSUM = 15;
    localparam int BIT_CERR   = 28;
    localparam int BIT_BADA   = 29;

    // positions that event pulses may set
    localparam logic [HALF_W-1:0] NORM_EVT_MASK = 16'h06FF;
    localparam logic [HALF_W-1:0] ERR_EVT_MASK  = 16'h037F;

    // every bit held in a write-one-to-clear flop
    localparam logic [STAT_W-1:0] W1C_MASK =
        {ERR_EVT_MASK, NORM_EVT_MASK}
        | (32'h1 << BIT_CERR) | (32'h1 << BIT_BADA);

    typedef enum logic [2:0] {
        RSP_NONE = 3'd0,
        RSP_R1   = 3'd1,
        RSP_R1B  = 3'd2,
        RSP_R2   = 3'd3,
        RSP_R3   = 3'd4,
        RSP_R5   = 3'd5,
        RSP_R5B  = 3'd6,
        RSP_R6   = 3'd7
    } rsp_kind_t;

    typedef enum logic [ADDR_W-1:0] {
        A_STATUS = 2'd0,
        A_ENABLE = 2'd1,
        A_CSERR  = 2'd2,
        A_DPORT  = 2'd3
    } reg_sel_t;
endpackage

// File: rtl/sdis_event_logic.sv
// Detects the two error conditions generated inside the block:
// illegal data-port access and masked card-status errors in responses.
// Assumes access strobes and rsp_valid are single-cycle.
module sdis_event_logic
    import sdis_pkg::*;
#(
    parameter logic [31:0] ERR_CLASS_MASK = 32'hFDF9_8008
) (
    input  logic        dport_rd,
    input  logic        dport_wr,
    input  logic        buf_rd_ok,
    input  logic        buf_wr_ok,
    input  logic        rsp_valid,
    input  logic [2:0]  rsp_kind,
    input  logic        rsp_auto12,
    input  logic [31:0] rsp_status,
    input  logic [31:0] cserr_en,
    output logic        bada_hit,
    output logic        cerr_hit
);
    logic kind_ok;

    // purpose: flag a data-port access the buffer does not allow
    always_comb bada_hit = (dport_rd && !buf_rd_ok) || (dport_wr && !buf_wr_ok);

    // purpose: pick the response kinds that carry card status
    always_comb begin
        unique case (rsp_kind_t'(rsp_kind))
            RSP_R1, RSP_R1B, RSP_R5, RSP_R5B, RSP_R6: kind_ok = 1'b1;
            default:                                  kind_ok = 1'b0;
        endcase
    end

    // purpose: raise a card error on any enabled error-class status bit
    always_comb cerr_hit = rsp_valid && kind_ok && !rsp_auto12
                           && |(rsp_status & ERR_CLASS_MASK & cserr_en);
endmodule

// File: rtl/sdis_status_bank.sv
// Bank of write-one-to-clear status flops. A set event wins over a
// clear in the same cycle. Positions outside SET_MASK are constant 0.
module sdis_status_bank #(
    parameter int                 W        = 32,
    parameter logic [W-1:0]       SET_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (SET_MASK[i]) begin : g_flop
            logic bit_q;
            // purpose: hold one status bit, set dominating clear
            always_ff @(posedge clk) begin
                if (!rst_n)          bit_q <= 1'b0;
                else if (set_vec[i]) bit_q <= 1'b1;
                else if (clr_vec[i]) bit_q <= 1'b0;
            end
            assign q[i] = bit_q;
        end else begin : g_const
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sdis_card_irq.sv
// Card-interrupt pending bit. Sets while the card requests and the
// enable is on; clears only once masked and the request is gone.
module sdis_card_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic card_irq,
    input  logic irq_en,
    output logic pending
);
    // purpose: track the card interrupt under its enable
    always_ff @(posedge clk) begin
        if (!rst_n)                     pending <= 1'b0;
        else if (card_irq && irq_en)    pending <= 1'b1;
        else if (!card_irq && !irq_en)  pending <= 1'b0;
    end
endmodule

// File: rtl/sdis_regport.sv
// Register port: decodes accesses, holds the enable and the error-enable
// mask, produces clear strobes and data-port access strobes, and
// returns registered read data one cycle after a read request.
module sdis_regport
    import sdis_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    input  logic [STAT_W-1:0] status_view,
    output logic [STAT_W-1:0] reg_rdata,
    output logic [STAT_W-1:0] clr_vec,
    output logic              irq_en,
    output logic [STAT_W-1:0] cserr_en,
    output logic              dport_rd,
    output logic              dport_wr
);
    logic wr_hit, rd_hit;

    // purpose: split a request into read and write
    always_comb begin
        wr_hit = reg_valid && reg_write;
        rd_hit = reg_valid && !reg_write;
    end

    // purpose: clear strobes and data-port access strobes
    always_comb begin
        clr_vec  = (wr_hit && reg_sel_t'(reg_addr) == A_STATUS) ? (reg_wdata & W1C_MASK) : '0;
        dport_rd = rd_hit && reg_sel_t'(reg_addr) == A_DPORT;
        dport_wr = wr_hit && reg_sel_t'(reg_addr) == A_DPORT;
    end

    // purpose: hold the software-written configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en   <= 1'b0;
            cserr_en <= '0;
        end else if (wr_hit) begin
            if (reg_sel_t'(reg_addr) == A_ENABLE) irq_en   <= reg_wdata[BIT_CIRQ];
            if (reg_sel_t'(reg_addr) == A_CSERR)  cserr_en <= reg_wdata;
        end
    end

    // purpose: register read data for the requested address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (rd_hit) begin
            unique case (reg_sel_t'(reg_addr))
                A_STATUS: reg_rdata <= status_view;
                A_ENABLE: reg_rdata <= STAT_W'(irq_en) << BIT_CIRQ;
                A_CSERR:  reg_rdata <= cserr_en;
                default:  reg_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/sd_irq_status.sv
// Top of the SD host interrupt status register. Combines the status
// bank, the card-interrupt bit, internal error detection and the
// register port. Bit 15 is the OR of the error half, formed here.
// Assumes event inputs are single-cycle pulses in the clk domain.
module sd_irq_status
    import sdis_pkg::*;
#(
    parameter logic [31:0] ERR_CLASS_MASK = 32'hFDF9_8008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic [HALF_W-1:0] norm_evt,
    input  logic [HALF_W-1:0] err_evt,
    input  logic              card_irq,
    input  logic              buf_rd_ok,
    input  logic              buf_wr_ok,
    input  logic              rsp_valid,
    input  logic [2:0]        rsp_kind,
    input  logic              rsp_auto12,
    input  logic [31:0]       rsp_status
);
    logic [STAT_W-1:0] clr_vec, set_vec, bank_q, status_view, cserr_en;
    logic              irq_en, cirq_pend, dport_rd, dport_wr, bada_hit, cerr_hit;

    sdis_regport u_port (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .status_view(status_view), .reg_rdata(reg_rdata),
        .clr_vec(clr_vec), .irq_en(irq_en), .cserr_en(cserr_en),
        .dport_rd(dport_rd), .dport_wr(dport_wr)
    );

    sdis_event_logic #(.ERR_CLASS_MASK(ERR_CLASS_MASK)) u_evt (
        .dport_rd(dport_rd), .dport_wr(dport_wr),
        .buf_rd_ok(buf_rd_ok), .buf_wr_ok(buf_wr_ok),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_auto12(rsp_auto12), .rsp_status(rsp_status),
        .cserr_en(cserr_en), .bada_hit(bada_hit), .cerr_hit(cerr_hit)
    );

    // purpose: merge external pulses and internal detections into set strobes
    always_comb begin
        set_vec = {err_evt & ERR_EVT_MASK, norm_evt & NORM_EVT_MASK};
        set_vec[BIT_CERR] = set_vec[BIT_CERR] | cerr_hit;
        set_vec[BIT_BADA] = set_vec[BIT_BADA] | bada_hit;
    end

    sdis_status_bank #(.W(STAT_W), .SET_MASK(W1C_MASK)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .set_vec(set_vec), .clr_vec(clr_vec), .q(bank_q)
    );

    sdis_card_irq u_cirq (
        .clk(clk), .rst_n(rst_n),
        .card_irq(card_irq), .irq_en(irq_en), .pending(cirq_pend)
    );

    // purpose: assemble the visible status word with the special bits
    always_comb begin
        status_view = bank_q;
        status_view[BIT_CIRQ]   = cirq_pend;
        status_view[BIT_ERRSUM] = |bank_q[STAT_W-1:HALF_W];
    end
endmodule

// File: rtl/sdis_checker.sv
// Property checker for sd_irq_status, attached through bind.
module sdis_checker
    import sdis_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [STAT_W-1:0] reg_rdata,
    input logic [HALF_W-1:0] norm_evt,
    input logic              card_irq,
    input logic              irq_en,
    input logic              rsp_valid,
    input logic              rsp_auto12,
    input logic [STAT_W-1:0] stat
);
    localparam logic [STAT_W-1:0] RSVD_MASK = 32'hCC80_7800;

    // R5
    errsum_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_valid && !reg_write && reg_addr == A_STATUS)
        |-> reg_rdata[BIT_ERRSUM] == |reg_rdata[STAT_W-1:HALF_W]);

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_valid && !reg_write && reg_addr == A_STATUS)
        |-> (reg_rdata & RSVD_MASK) == '0);

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        norm_evt[0] |=> stat[0]);

    // R6
    cirq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (card_irq && irq_en) |=> stat[BIT_CIRQ]);

    // R9
    auto12_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_auto12 && !stat[BIT_CERR]
         && !(reg_valid && reg_addr == A_CSERR)) |=> !stat[BIT_CERR]);
endmodule

bind sd_irq_status sdis_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .norm_evt(norm_evt), .card_irq(card_irq), .irq_en(irq_en),
    .rsp_valid(rsp_valid), .rsp_auto12(rsp_auto12),
    .stat(status_view)
);

// File: tb/sd_irq_status_test.sv
`timescale 1ns/100ps
module sd_irq_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] norm_evt = '0, err_evt = '0;
    logic        card_irq = 1'b0, buf_rd_ok = 1'b1, buf_wr_ok = 1'b1;
    logic        rsp_valid = 1'b0, rsp_auto12 = 1'b0;
    logic [2:0]  rsp_kind = '0;
    logic [31:0] rsp_status = '0;

    int tests = 0, fails = 0, cycles = 0;

    always #2.5 clk = ~clk;

    sd_irq_status uut (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .norm_evt(norm_evt), .err_evt(err_evt), .card_irq(card_irq),
        .buf_rd_ok(buf_rd_ok), .buf_wr_ok(buf_wr_ok),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_auto12(rsp_auto12), .rsp_status(rsp_status)
    );

    // vectors: {norm pulse, err pulse, expected status}
    localparam int NV = 5;
    localparam logic [63:0] VEC [NV] = '{
        {16'hFFFF, 16'h0000, 32'h0000_06FF},
        {16'h0001, 16'h0001, 32'h0001_8001},
        {16'h0000, 16'hFFFF, 32'h037F_8000},
        {16'h8100, 16'h8C80, 32'h0000_0000},
        {16'h0420, 16'h0200, 32'h0200_8420}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [15:0] n, input logic [15:0] e);
        @(negedge clk);
        norm_evt = n; err_evt = e;
        @(negedge clk);
        norm_evt = '0; err_evt = '0;
    endtask

    task automatic rsp(input logic [2:0] k, input logic a12, input logic [31:0] s);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_kind = k; rsp_auto12 = a12; rsp_status = s;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected below 20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 rdata", reg_rdata, 32'h0);
        rd(2'd0, v); chk("R1 status", v, 32'h0);
        rd(2'd1, v); chk("R1 enable", v, 32'h0);
        rd(2'd2, v); chk("R1 cserr", v, 32'h0);

        // R2 vector walk
        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i][63:48], VEC[i][47:32]);
            rd(2'd0, v); chk("R2 vector set", v, VEC[i][31:0]);
            wr(2'd0, 32'hFFFF_FFFF);
            rd(2'd0, v); chk("R3 clear all", v, 32'h0);
        end

        // R3 partial clear and zero write
        pulse(16'h0003, 16'h0000);
        wr(2'd0, 32'h0000_0001);
        rd(2'd0, v); chk("R3 partial", v, 32'h0000_0002);
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R3 zero write", v, 32'h0000_0002);
        wr(2'd0, 32'hFFFF_FFFF);

        // R4 set and clear in the same cycle
        @(negedge clk);
        norm_evt = 16'h0001;
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h1;
        @(negedge clk);
        norm_evt = '0; reg_valid = 1'b0; reg_write = 1'b0;
        rd(2'd0, v); chk("R4 set wins", v, 32'h0000_0001);
        wr(2'd0, 32'hFFFF_FFFF);

        // R5 summary bit
        pulse(16'h0, 16'h0003);
        wr(2'd0, 32'h0001_0000);
        rd(2'd0, v); chk("R5 still pending", v, 32'h0002_8000);
        wr(2'd0, 32'h0000_8000);
        rd(2'd0, v); chk("R5 write ignored", v, 32'h0002_8000);
        wr(2'd0, 32'h0002_0000);
        rd(2'd0, v); chk("R5 self clear", v, 32'h0);

        // R10 reserved and enable readback
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R10 enable bits", v, 32'h0000_0100);
        wr(2'd1, 32'h0);

        // R6 card interrupt
        @(negedge clk); card_irq = 1'b1;
        repeat (2) @(negedge clk);
        rd(2'd0, v); chk("R6 masked no set", v, 32'h0);
        wr(2'd1, 32'h0000_0100);
        rd(2'd0, v); chk("R6 set", v, 32'h0000_0100);
        wr(2'd0, 32'h0000_0100);
        rd(2'd0, v); chk("R6 w1c ignored", v, 32'h0000_0100);
        @(negedge clk); card_irq = 1'b0;
        rd(2'd0, v); chk("R6 enabled hold", v, 32'h0000_0100);
        wr(2'd1, 32'h0);
        rd(2'd0, v); chk("R6 clear", v, 32'h0);

        // R7 bad access
        buf_rd_ok = 1'b0;
        rd(2'd3, v); chk("R11 dport reads 0", v, 32'h0);
        rd(2'd0, v); chk("R7 bad read", v, 32'h2000_8000);
        wr(2'd0, 32'h2000_0000);
        buf_rd_ok = 1'b1;
        rd(2'd3, v);
        rd(2'd0, v); chk("R7 good read", v, 32'h0);
        buf_wr_ok = 1'b0;
        wr(2'd3, 32'h1234_5678);
        rd(2'd0, v); chk("R7 bad write", v, 32'h2000_8000);
        wr(2'd0, 32'h2000_0000);
        buf_wr_ok = 1'b1;
        wr(2'd3, 32'h1234_5678);
        rd(2'd0, v); chk("R7 good write", v, 32'h0);

        // R8 card error
        wr(2'd2, 32'h0008_0000);
        rd(2'd2, v); chk("R11 cserr readback", v, 32'h0008_0000);
        rsp(3'd1, 1'b0, 32'h0008_0000);
        rd(2'd0, v); chk("R8 R1 error", v, 32'h1000_8000);
        wr(2'd0, 32'h1000_0000);
        rsp(3'd3, 1'b0, 32'h0008_0000);
        rd(2'd0, v); chk("R8 R2 ignored", v, 32'h0);
        rsp(3'd1, 1'b0, 32'h0040_0000);
        rd(2'd0, v); chk("R8 not enabled", v, 32'h0);
        rsp(3'd7, 1'b0, 32'h0008_0000);
        rd(2'd0, v); chk("R8 R6 error", v, 32'h1000_8000);
        wr(2'd0, 32'h1000_0000);
        wr(2'd2, 32'hFFFF_FFFF);
        rsp(3'd5, 1'b0, 32'h0200_0000);
        rd(2'd0, v); chk("R8 non-error bit", v, 32'h0);

        // R9 automatic stop response
        rsp(3'd1, 1'b1, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R9 auto12 ignored", v, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule